// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 2M byte locations. The RAM has two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one shared 8-bit bidirectional data bus. The host hands over one read or one write at a time through a valid/ready handshake. The block plays out the matching control waveform on the RAM pins and finishes each request with a one-cycle response pulse. For a read, that pulse carries the byte it fetched.

Each phase of the waveform lasts a whole number of clock cycles. These counts are computed at elaboration from a clock-period parameter and from the RAM's nanosecond minimums. The conversion rounds up, and any phase with a nonzero minimum gets at least one cycle. Between requests the RAM is deselected, which keeps it in standby and its outputs in high impedance.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every cycle the block is idle, it holds mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, req_ready=1 and rsp_valid=0.
- R2: A request is taken on a clock edge where req_valid=1 and req_ready=1. req_ready then stays 0 until the edge that raises rsp_valid.
- R3: A read keeps the RAM selected (mem_ce1_n=0, mem_ce2=1) with mem_oe_n=0 and mem_we_n=1 for RD cycles. RD is the largest of ceil(70/CLK_NS) and ceil(30/CLK_NS), which is 7 at CLK_NS=10. The byte on the bus is captured at the edge that ends this window, so rsp_valid is seen RD+1 cycles after the accepting edge.
- R4: A write keeps the RAM selected for three phases. First comes a turnaround of TA=ceil(25/CLK_NS) cycles with mem_we_n=1 and mem_oe_n=1. Next is a pulse of WP cycles with mem_we_n=0, where WP is the largest of ceil(35/CLK_NS), ceil(30/CLK_NS), ceil(50/CLK_NS)-TA and 1. Last is a recovery of REC=max(1, ceil(70/CLK_NS)-TA-WP) cycles with mem_we_n=1. At CLK_NS=10 this gives 3, 4 and 1 cycles, and rsp_valid is seen 9 cycles after the accepting edge. mem_we_n is low only while the RAM is selected.
- R5: mem_addr equals the accepted req_addr (all 21 bits) and does not change while the RAM is selected.
- R6: mem_we_n and mem_oe_n are never both 0. The block drives mem_dq only while mem_we_n=0, and it drives the accepted write byte there.
- R7: rsp_valid is a one-cycle pulse, once per completed request. After a read, rsp_rdata holds the byte most recently written to that address.
- R8: A write does not change rsp_rdata. The last read byte is held until the next read completes.
- R9: A synchronous reset asserted in the middle of a write returns the block to the idle pin state of R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Block idle, request can be taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 21 | RAM address |
| mem_ce1_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq | inout | 8 | RAM data bus |

## Verification
The main path is tested with a mix of writes and reads at addresses whose upper bits run from all zeros to all ones. This shows whether the full address reaches the pins and whether each read returns its own location instead of a neighbour's. The sequence includes a write that overwrites an earlier byte with zero, followed by a read of that address. This separates a real write from stale data or a bus that was never driven. Reads placed between writes, and writes placed between reads, show whether rsp_rdata is held or corrupted by a write. For every request, the phase lengths measured at the pins and the response latency are compared with the cycle counts worked out from the nanosecond minimums. A reset during the write pulse checks that the block abandons the access cleanly.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS
  } seq_state_t;

  // round a nanosecond minimum up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drv_en,
  input  logic [DW-1:0] wdata,
  input  logic          cap_en,
  inout  wire  [DW-1:0] dq,
  output logic [DW-1:0] rdata
);

  assign dq = drv_en ? wdata : {DW{1'bz}};

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (cap_en) rdata <= dq;
  end

  // a capture must never sample our own drive
  assert_cap_undriven_R6: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> !drv_en);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_pkg::*;
#(
  parameter int AW  = 21,
  parameter int DW  = 8,
  parameter int CW  = 3,
  parameter int TA  = 3,
  parameter int WP  = 4,
  parameter int REC = 1,
  parameter int RD  = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          tmr_expired,
  output logic          req_ready,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic [AW-1:0] mem_addr,
  output logic          ce1_n,
  output logic          ce2,
  output logic          we_n,
  output logic          oe_n,
  output logic          drv_en,
  output logic [DW-1:0] wdata_q,
  output logic          cap_en,
  output logic          done
);

  localparam logic [CW-1:0] TA_V  = CW'(TA - 1);
  localparam logic [CW-1:0] WP_V  = CW'(WP - 1);
  localparam logic [CW-1:0] REC_V = CW'(REC - 1);
  localparam logic [CW-1:0] RD_V  = CW'(RD - 1);

  seq_state_t state;

  assign req_ready = (state == ST_IDLE);
  assign cap_en    = (state == ST_RACCESS) && tmr_expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        tmr_val  = req_we ? TA_V : RD_V;
      end
      ST_WSETUP: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = WP_V;
      end
      ST_WPULSE: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = REC_V;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_addr <= '0;
      wdata_q  <= '0;
      ce1_n    <= 1'b1;
      ce2      <= 1'b0;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      drv_en   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          wdata_q  <= req_wdata;
          ce1_n    <= 1'b0;
          ce2      <= 1'b1;
          if (req_we) begin
            state <= ST_WSETUP;
          end else begin
            state <= ST_RACCESS;
            oe_n  <= 1'b0;
          end
        end
        ST_WSETUP: if (tmr_expired) begin
          state  <= ST_WPULSE;
          we_n   <= 1'b0;
          drv_en <= 1'b1;
        end
        ST_WPULSE: if (tmr_expired) begin
          state  <= ST_WHOLD;
          we_n   <= 1'b1;
          drv_en <= 1'b0;
        end
        ST_WHOLD: if (tmr_expired) begin
          state <= ST_IDLE;
          ce1_n <= 1'b1;
          ce2   <= 1'b0;
          done  <= 1'b1;
        end
        ST_RACCESS: if (tmr_expired) begin
          state <= ST_IDLE;
          ce1_n <= 1'b1;
          ce2   <= 1'b0;
          oe_n  <= 1'b1;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_we_oe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

  assert_we_in_select_R4: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce1_n && ce2));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 30,
  parameter int T_WC_NS   = 70,
  parameter int T_AW_NS   = 50,
  parameter int T_CW_NS   = 50,
  parameter int T_WP_NS   = 35,
  parameter int T_DW_NS   = 30,
  parameter int T_OHZ_NS  = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  inout  wire  [DW-1:0] mem_dq
);

  localparam int TA   = max2(ns_to_cyc(T_OHZ_NS, CLK_NS), 1);
  localparam int WP_A = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int WP_B = max2(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)) - TA;
  localparam int WP   = max2(max2(WP_A, WP_B), 1);
  localparam int REC  = max2(ns_to_cyc(T_WC_NS, CLK_NS) - TA - WP, 1);
  localparam int RD_A = max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
  localparam int RD   = max2(max2(RD_A, ns_to_cyc(T_OE_NS, CLK_NS)), 1);
  localparam int MAXP = max2(max2(TA, WP), max2(REC, RD));
  localparam int CW   = max2($clog2(MAXP + 1), 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  logic          drv_en;
  logic [DW-1:0] wdata_q;
  logic          cap_en;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .AW(AW), .DW(DW), .CW(CW), .TA(TA), .WP(WP), .REC(REC), .RD(RD)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .tmr_expired (tmr_expired),
    .req_ready   (req_ready),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .mem_addr    (mem_addr),
    .ce1_n       (mem_ce1_n),
    .ce2         (mem_ce2),
    .we_n        (mem_we_n),
    .oe_n        (mem_oe_n),
    .drv_en      (drv_en),
    .wdata_q     (wdata_q),
    .cap_en      (cap_en),
    .done        (rsp_valid)
  );

  sram_dq_port #(.DW(DW)) u_dq (
    .clk    (clk),
    .rst    (rst),
    .drv_en (drv_en),
    .wdata  (wdata_q),
    .cap_en (cap_en),
    .dq     (mem_dq),
    .rdata  (rsp_rdata)
  );

  assert_ready_standby_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  assert_drive_only_write_R6: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> !mem_we_n);

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [20:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n;
  wire  [7:0]  mem_dq;

  always #5 clk = ~clk;

  sram_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  // RAM model, indexed by the low address byte
  logic [7:0] ram [256];
  logic sel;
  assign sel = !mem_ce1_n && mem_ce2;
  assign mem_dq = (sel && mem_we_n && !mem_oe_n) ? ram[mem_addr[7:0]] : 8'bz;

  initial for (int i = 0; i < 256; i++) ram[i] = 8'h00;

  // timing expectations from the nanosecond minimums at 10 ns
  function automatic int up(input int ns);
    return (ns + 9) / 10;
  endfunction
  int e_ta, e_wp, e_rec, e_rd;
  initial begin
    e_ta  = up(25);
    e_wp  = up(35);
    if (up(30) > e_wp) e_wp = up(30);
    if (up(50) - e_ta > e_wp) e_wp = up(50) - e_ta;
    e_rec = up(70) - e_ta - e_wp;
    if (e_rec < 1) e_rec = 1;
    e_rd  = up(70);
  end

  // pin monitor
  int sel_run = 0, we_run = 0, pre_run = 0;
  int sel_len = 0, we_len = 0, pre_len = 0;
  int addr_bad = 0, excl_bad = 0, data_bad = 0, we_outside = 0;
  logic sel_prev = 1'b0;
  logic [20:0] last_addr = '0, seen_addr = '0;
  logic [7:0] cur_wdata = '0;

  always @(negedge clk) begin
    if (!mem_we_n && !mem_oe_n) excl_bad++;
    if (!mem_we_n && !sel) we_outside++;
    if (sel) begin
      sel_run++;
      if (sel_run > 1 && mem_addr != last_addr) addr_bad++;
      last_addr = mem_addr;
      if (!mem_we_n) begin
        we_run++;
        if (mem_dq !== cur_wdata) data_bad++;
        ram[mem_addr[7:0]] = mem_dq;
      end else if (we_run == 0) begin
        pre_run++;
      end
    end else if (sel_prev) begin
      sel_len = sel_run; we_len = we_run; pre_len = pre_run;
      seen_addr = last_addr;
      sel_run = 0; we_run = 0; pre_run = 0;
    end
    sel_prev = sel;
  end

  int total = 0, fails = 0, lat = 0;
  logic [7:0] last_rd = '0;

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic run_req(input logic we, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    if (we) cur_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk("R2 ready low while busy", int'(req_ready), 0);
    while (!rsp_valid) begin @(negedge clk); lat++; end
    #1;
  endtask

  // {we, addr, data or expected byte}
  localparam logic [29:0] VEC [8] = '{
    {1'b1, 21'h000012, 8'hA5},
    {1'b1, 21'h1FFF34, 8'h5A},
    {1'b1, 21'h0ABC56, 8'hFF},
    {1'b0, 21'h000012, 8'hA5},
    {1'b0, 21'h1FFF34, 8'h5A},
    {1'b1, 21'h000012, 8'h00},
    {1'b0, 21'h000012, 8'h00},
    {1'b0, 21'h0ABC56, 8'hFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce1_n", int'(mem_ce1_n), 1);
    chk("R1 ce2", int'(mem_ce2), 0);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    repeat (5) @(negedge clk);
    chk("R1 idle stays deselected", int'({mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}), 4'b1011);

    for (int v = 0; v < 8; v++) begin
      logic        we;
      logic [20:0] a;
      logic [7:0]  d;
      {we, a, d} = VEC[v];
      run_req(we, a, d);
      chk("R7 rsp_valid", int'(rsp_valid), 1);
      chk("R5 address at pins", int'(seen_addr), int'(a));
      if (we) begin
        chk("R4 latency", lat, e_ta + e_wp + e_rec + 1);
        chk("R4 turnaround", pre_len, e_ta);
        chk("R4 we pulse", we_len, e_wp);
        chk("R4 selected length", sel_len, e_ta + e_wp + e_rec);
        chk("R8 rdata held over write", int'(rsp_rdata), int'(last_rd));
      end else begin
        chk("R3 latency", lat, e_rd + 1);
        chk("R3 selected length", sel_len, e_rd);
        chk("R3 no we pulse", we_len, 0);
        chk("R7 read data", int'(rsp_rdata), int'(d));
        last_rd = d;
      end
      @(negedge clk);
      chk("R7 single pulse", int'(rsp_valid), 0);
      chk("R8 rdata holds", int'(rsp_rdata), int'(last_rd));
    end

    // R9: reset during the write pulse
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 21'h00FF99; req_wdata = 8'h77;
    cur_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    while (mem_we_n) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 pins idle after reset", int'({mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}), 4'b1011);
    chk("R9 ready after reset", int'(req_ready), 1);
    chk("R9 no response", int'(rsp_valid), 0);
    rst = 1'b0;
    run_req(1'b0, 21'h0ABC56, 8'h00);
    chk("R9 read after reset", int'(rsp_rdata), 8'hFF);

    chk("R5 address stable", addr_bad, 0);
    chk("R6 we/oe exclusive", excl_bad, 0);
    chk("R6 write byte on bus", data_bad, 0);
    chk("R4 we only when selected", we_outside, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule